// File: doc/BRIEF.md
# Grouped Interrupt Expander

The expander gathers a large set of peripheral request lines into a few groups and presents one interrupt line per group to the processor. Each source has its own pending flag and its own enable bit. Each group has a sticky acknowledge latch that silences the whole group once one of its interrupts has been taken, until software releases it.

When the processor fetches a vector, the block picks the highest-priority source that is pending, enabled and in a group whose latch is clear. Lower group numbers beat higher ones, and within a group lower source numbers win. The block returns that source's vector index one cycle later, clears its flag and sets its group's latch. Software reads and writes enables, reads flags and releases latches through a small register port. Selection happens only at a fetch, so nothing preempts an interrupt that is already in service.

Top module: `irq_group_expander`

## Requirements
- R1: After reset all flags, enables and acknowledge latches are zero, every group interrupt output is low and no vector is valid.
- R2: A one-cycle pulse on a request line sets that source's flag, readable from the next cycle, whatever the state of its enable. The flag stays set until its vector is taken.
- R3: Group output g is high exactly when group g's latch is clear and at least one of its sources has both its flag and its enable set.
- R4: One cycle after a fetch request, the valid strobe is high for that single cycle, carrying index g*8+s. Here g is the lowest eligible group and s is the lowest eligible source inside it.
- R5: The fetch clears the taken source's flag and sets its group's acknowledge latch.
- R6: While a group's latch is set, none of its sources raises the group output or is returned by a fetch. A fetch with no eligible source leaves the valid strobe low.
- R7: Writing the acknowledge register clears the latch of every group whose data bit g is 1. Bits written as 0 leave their latch as it was. A latch release changes no flag and no enable.
- R8: When a latch is released while a source in that group is pending and enabled, the group output rises at once, and the next fetch takes the lowest pending source of that group.
- R9: If a source's request pulse arrives in the same cycle as the fetch that takes it, the flag remains set afterwards.
- R10: The vector is chosen from the state at the fetch cycle. A higher-priority source flagged while another interrupt is in service waits and is taken at the next fetch.
- R11: Register map on the read/write port: address g (0 to 11) is group g's enable byte, with bit s for source s; address 12+g is group g's flag byte, read only, writes ignored; address 24 holds the acknowledge latches in bits 11:0, with write-one-to-clear; other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 96 | One-cycle request pulses, source g*8+s at bit g*8+s |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address for read and write |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read data, combinational from the address |
| cpu_int_o | output | 12 | Per-group interrupt lines to the processor |
| vec_req_i | input | 1 | Vector fetch request |
| vec_valid_o | output | 1 | One-cycle strobe: a vector was taken |
| vec_idx_o | output | 7 | Index of the taken vector |

## Verification
A corrupted flag, enable or latch appears on the group interrupt lines in the same cycle and in the read-back registers at once. A wrong priority decision or a lost flag shows as a wrong index on the cycle after a fetch. The bench keeps its own model of flags, enables and latches. It drives every source singly, every pair of groups against each other, and the corner cases: a latch release with requests already waiting, a request coinciding with its own fetch, and a late-arriving higher-priority request. It compares the group lines and every fetch result with that model.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned GPX_GROUPS  = 12;
  localparam int unsigned GPX_SOURCES = 8;

  typedef enum logic [1:0] {
    BANK_ENABLE,
    BANK_FLAG,
    BANK_ACK,
    BANK_NONE
  } gpx_bank_e;
endpackage

// File: rtl/gpx_prio.sv
module gpx_prio #(
  parameter  int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  // Lowest set bit wins: scan downward so the last hit is the lowest index.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
    onehot_o = found_o ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/gpx_group.sv
module gpx_group #(
  parameter int unsigned SRC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SRC-1:0] req_i,
  input  logic           en_we_i,
  input  logic [SRC-1:0] en_wdata_i,
  input  logic           take_i,
  input  logic [SRC-1:0] take_oh_i,
  input  logic           ack_clr_i,
  output logic [SRC-1:0] flag_o,
  output logic [SRC-1:0] en_o,
  output logic           ack_o,
  output logic [SRC-1:0] live_o
);
  logic [SRC-1:0] flag_q, flag_d;
  logic [SRC-1:0] en_q, en_d;
  logic           ack_q, ack_d;
  logic           flag_ce, en_ce, ack_ce;

  // Next state: a new request beats the clear of a taken flag.
  always_comb begin
    flag_ce = take_i | (|req_i);
    flag_d  = (flag_q & ~(take_i ? take_oh_i : '0)) | req_i;
    en_ce   = en_we_i;
    en_d    = en_wdata_i;
    ack_ce  = take_i | ack_clr_i;
    ack_d   = take_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      if (flag_ce) flag_q <= flag_d;
      if (en_ce)   en_q   <= en_d;
      if (ack_ce)  ack_q  <= ack_d;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign ack_o  = ack_q;
  assign live_o = ack_q ? '0 : (flag_q & en_q);

  a_r5_take_sets_ack: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> ack_q);
  a_r5_take_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !(|(take_oh_i & req_i))) |=> !(|(flag_q & $past(take_oh_i))));
  a_r9_request_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && (|(take_oh_i & req_i))) |=> (|(flag_q & $past(take_oh_i))));
  a_r7_flags_drop_only_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  a_r6_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !ack_clr_i) |=> ack_q);
endmodule

// File: rtl/irq_group_expander.sv
module irq_group_expander #(
  parameter  int unsigned GROUPS  = gpx_pkg::GPX_GROUPS,
  parameter  int unsigned SOURCES = gpx_pkg::GPX_SOURCES,
  localparam int unsigned NSRC    = GROUPS * SOURCES,
  localparam int unsigned VW      = $clog2(NSRC),
  localparam int unsigned GW      = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int unsigned SW      = (SOURCES > 1) ? $clog2(SOURCES) : 1,
  localparam int unsigned DW      = (SOURCES > GROUPS) ? SOURCES : GROUPS,
  localparam int unsigned AW      = $clog2(2 * GROUPS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req_i,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [GROUPS-1:0] cpu_int_o,
  input  logic            vec_req_i,
  output logic            vec_valid_o,
  output logic [VW-1:0]   vec_idx_o
);
  import gpx_pkg::*;

  gpx_bank_e          bank;
  logic [GW-1:0]      sel;
  logic [SOURCES-1:0] flag_a [GROUPS];
  logic [SOURCES-1:0] en_a   [GROUPS];
  logic [SOURCES-1:0] live_a [GROUPS];
  logic [GROUPS-1:0]  ack_v, grp_any, grp_oh;
  logic               grp_found, src_found;
  logic [GW-1:0]      win_grp;
  logic [SW-1:0]      win_src;
  logic [SOURCES-1:0] win_live, src_oh;
  logic               vld_d, vld_q;
  logic [VW-1:0]      idx_d, idx_q;

  // Address decode into bank and group select.
  always_comb begin
    sel  = '0;
    bank = BANK_NONE;
    if (reg_addr_i < AW'(GROUPS)) begin
      bank = BANK_ENABLE;
      sel  = GW'(reg_addr_i);
    end else if (reg_addr_i < AW'(2 * GROUPS)) begin
      bank = BANK_FLAG;
      sel  = GW'(reg_addr_i - AW'(GROUPS));
    end else if (reg_addr_i == AW'(2 * GROUPS)) begin
      bank = BANK_ACK;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic ack_bit;
    gpx_group #(.SRC(SOURCES)) u_group (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (irq_req_i[g*SOURCES +: SOURCES]),
      .en_we_i    (reg_we_i && (bank == BANK_ENABLE) && (sel == GW'(g))),
      .en_wdata_i (reg_wdata_i[SOURCES-1:0]),
      .take_i     (vec_req_i && grp_oh[g]),
      .take_oh_i  (src_oh),
      .ack_clr_i  (reg_we_i && (bank == BANK_ACK) && reg_wdata_i[g]),
      .flag_o     (flag_a[g]),
      .en_o       (en_a[g]),
      .ack_o      (ack_bit),
      .live_o     (live_a[g])
    );
    assign ack_v[g]   = ack_bit;
    assign grp_any[g] = |live_a[g];
  end

  assign cpu_int_o = grp_any;

  // Two-level arbitration: lowest group first, then lowest source in it.
  gpx_prio #(.N(GROUPS)) u_grp_prio (
    .req_i    (grp_any),
    .found_o  (grp_found),
    .idx_o    (win_grp),
    .onehot_o (grp_oh)
  );

  assign win_live = live_a[win_grp];

  gpx_prio #(.N(SOURCES)) u_src_prio (
    .req_i    (win_live),
    .found_o  (src_found),
    .idx_o    (win_src),
    .onehot_o (src_oh)
  );

  always_comb begin
    vld_d = vec_req_i && grp_found && src_found;
    idx_d = vld_d ? VW'(win_grp * SOURCES + win_src) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (vld_d || vld_q) idx_q <= idx_d;
    end
  end

  assign vec_valid_o = vld_q;
  assign vec_idx_o   = idx_q;

  // Read mux.
  always_comb begin
    reg_rdata_o = '0;
    case (bank)
      BANK_ENABLE: reg_rdata_o = DW'(en_a[sel]);
      BANK_FLAG:   reg_rdata_o = DW'(flag_a[sel]);
      BANK_ACK:    reg_rdata_o = DW'(ack_v);
      default:     reg_rdata_o = '0;
    endcase
  end

  logic [GW-1:0]     vgrp;
  logic [GROUPS-1:0] vmask_below, vmask_self;
  assign vgrp        = GW'(vec_idx_o / VW'(SOURCES));
  assign vmask_self  = GROUPS'(1) << vgrp;
  assign vmask_below = vmask_self - GROUPS'(1);

  a_r4_strobe_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(vec_req_i));
  a_r3_taken_group_was_raised: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (|($past(cpu_int_o) & vmask_self)));
  a_r4_no_lower_group_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (($past(cpu_int_o) & vmask_below) == '0));
  a_r6_no_vector_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_i && (cpu_int_o == '0)) |=> !vec_valid_o);
endmodule

// File: tb/test_irq_group_expander.sv
module test_irq_group_expander;
  localparam int G = 12, S = 8, N = 96, AW = 5, DW = 12, VW = 7;
  localparam int ACK_ADDR = 2 * G;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_req;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [G-1:0]  cpu_int;
  logic          vec_req;
  logic          vec_valid;
  logic [VW-1:0] vec_idx;

  always #5 clk = ~clk;

  irq_group_expander i_irq_group_expander (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cpu_int_o(cpu_int), .vec_req_i(vec_req), .vec_valid_o(vec_valid),
    .vec_idx_o(vec_idx)
  );

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_flag, m_en;
  logic [G-1:0] m_ack;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [G-1:0] exp_cpu();
    logic [G-1:0] r = '0;
    for (int g = 0; g < G; g++)
      for (int s = 0; s < S; s++)
        if (m_flag[g*S+s] && m_en[g*S+s] && !m_ack[g]) r[g] = 1'b1;
    return r;
  endfunction

  function automatic int exp_vec();
    for (int g = 0; g < G; g++)
      if (!m_ack[g])
        for (int s = 0; s < S; s++)
          if (m_flag[g*S+s] && m_en[g*S+s]) return g * S + s;
    return -1;
  endfunction

  task automatic check_cpu(input string tag);
    logic [G-1:0] e = exp_cpu();
    chk(cpu_int == e, tag, int'(cpu_int), int'(e));
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(addr); reg_wdata = DW'(data);
    @(negedge clk);
    reg_we = 1'b0;
    if (addr < G) m_en[addr*S +: S] = data[S-1:0];
    else if (addr == ACK_ADDR) m_ack = m_ack & ~data[G-1:0];
  endtask

  task automatic rd_chk(input int addr, input int exp, input string tag);
    @(negedge clk);
    reg_addr = AW'(addr);
    #1;
    chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    irq_req[src] = 1'b1;
    @(negedge clk);
    irq_req = '0;
    m_flag[src] = 1'b1;
  endtask

  task automatic fetch(input string tag, input int also_req);
    int e = exp_vec();
    @(negedge clk);
    vec_req = 1'b1;
    if (also_req >= 0) irq_req[also_req] = 1'b1;
    @(negedge clk);
    vec_req = 1'b0;
    irq_req = '0;
    chk(vec_valid == (e >= 0), tag, int'(vec_valid), int'(e >= 0));
    if (e >= 0) begin
      chk(int'(vec_idx) == e, tag, int'(vec_idx), e);
      m_flag[e] = 1'b0;
      m_ack[e / S] = 1'b1;
    end
    if (also_req >= 0) m_flag[also_req] = 1'b1;
    check_cpu(tag);
    @(negedge clk);
    chk(vec_valid == 1'b0, {tag, " strobe width"}, int'(vec_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    vec_req = 1'b0;
    m_flag = '0; m_en = '0; m_ack = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cpu_int == '0, "R1 cpu_int", int'(cpu_int), 0);
    chk(vec_valid == 1'b0, "R1 vec_valid", int'(vec_valid), 0);
    for (int a = 0; a <= ACK_ADDR; a++) rd_chk(a, 0, "R1 register");
    @(negedge clk);
    rst_n = 1'b1;

    // R11 enable registers read back
    for (int g = 0; g < G; g++) wr(g, 'hFF);
    for (int g = 0; g < G; g++) rd_chk(g, 'hFF, "R11 enable readback");

    // Sweep every source on its own: R2 R3 R4 R5 R7
    for (int src = 0; src < N; src++) begin
      pulse(src);
      rd_chk(G + src / S, 1 << (src % S), "R2 flag set");
      check_cpu("R3 group line");
      fetch("R4 single source", -1);
      rd_chk(ACK_ADDR, 1 << (src / S), "R5 ack set");
      rd_chk(G + src / S, 0, "R5 flag cleared");
      wr(ACK_ADDR, 0);
      rd_chk(ACK_ADDR, 1 << (src / S), "R7 zero write keeps ack");
      wr(ACK_ADDR, 1 << (src / S));
      rd_chk(ACK_ADDR, 0, "R7 ack cleared");
      check_cpu("R3 after release");
    end

    // Disabled source: flag kept, no line, no vector (R2 R3 R6)
    wr(3, 0);
    pulse(26);
    check_cpu("R3 disabled source");
    fetch("R6 nothing eligible", -1);
    rd_chk(G + 3, 1 << 2, "R2 flag kept while disabled");
    wr(3, 'hFF);
    check_cpu("R3 enable raises line");
    fetch("R4 after enable", -1);
    wr(ACK_ADDR, 'hFFF);

    // Group blocking and re-arm with pending source (R4 R6 R7 R8)
    pulse(61); pulse(22); pulse(19);
    fetch("R4 lowest group and source", -1);
    check_cpu("R6 group 2 blocked");
    fetch("R6 next group taken", -1);
    fetch("R6 all blocked", -1);
    wr(ACK_ADDR, 1 << 2);
    rd_chk(G + 2, 1 << 6, "R7 release keeps flags");
    rd_chk(2, 'hFF, "R7 release keeps enables");
    check_cpu("R8 line rises on release");
    fetch("R8 pending source taken", -1);
    wr(ACK_ADDR, 'hFFF);

    // Request coinciding with its own fetch (R9)
    pulse(40);
    fetch("R9 taken with coincident request", 40);
    rd_chk(G + 5, 1, "R9 flag survives");
    wr(ACK_ADDR, 1 << 5);
    fetch("R9 taken again", -1);
    wr(ACK_ADDR, 'hFFF);

    // No preemption (R10)
    pulse(45);
    fetch("R10 first service", -1);
    pulse(3);
    chk(vec_valid == 1'b0, "R10 no vector without fetch", int'(vec_valid), 0);
    check_cpu("R10 higher group waits");
    fetch("R10 taken at next fetch", -1);
    wr(ACK_ADDR, 'hFFF);

    // Flag registers read only, unused addresses read zero (R11)
    pulse(90);
    wr(G + 11, 'hFF);
    rd_chk(G + 11, 4, "R11 flag write ignored");
    wr(G + 11, 0);
    rd_chk(G + 11, 4, "R11 flag write ignored");
    fetch("R11 vector after flag writes", -1);
    wr(ACK_ADDR, 'hFFF);
    for (int a = ACK_ADDR + 1; a < 32; a++) rd_chk(a, 0, "R11 unused address");

    // Every pair of groups against each other (R4 R6)
    for (int g1 = 0; g1 < G; g1++) begin
      for (int g2 = g1 + 1; g2 < G; g2++) begin
        pulse(g2 * S + (g1 % S));
        pulse(g1 * S + 7 - (g2 % S));
        fetch("R4 pair priority", -1);
        fetch("R6 pair second", -1);
        wr(ACK_ADDR, 'hFFF);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule